// File: doc/BRIEF.md
# Branch Target Buffer with Saturating Direction Counters

This block predicts the next fetch address of a word-addressed pipeline. Every cycle the fetch stage presents its current PC, and in the same cycle the block returns a predicted next PC. The table is direct indexed. Each entry holds a valid flag, an address tag, the target the branch went to the last time it was taken, and a 2-bit saturating counter that sets the predicted direction. When the lookup misses, or when the counter leans toward not taken, the prediction is the sequential address PC+1. That address is computed and never stored.

A second port belongs to the stage that resolves branches. It supplies the branch PC, the actual direction and the actual target. The block uses them to allocate the entry or to update it. In the same cycle it raises a mispredict flag for the squash logic. The flag compares the resolved branch with the prediction that the table, as it stands, gives for that PC.

Top module: `btb_top`

## Requirements
- R1: After reset every entry is invalid, so `predTaken` is 0 and `predNextPc` equals `fetchPc`+1 for every fetch PC.
- R2: When the fetch lookup misses (entry invalid or tag different), `predTaken` is 0 and `predNextPc` is `fetchPc`+1, wrapping modulo 2^PC_W.
- R3: The table index is the low IDX_W bits of a PC and the tag is the remaining upper bits. A PC with the same index but a different tag misses. An update with the new tag replaces the old entry.
- R4: An update that misses allocates the entry. It stores the tag and `updTarget`, whatever the direction. The counter is set to 2 for a taken branch and to 1 for a not-taken branch.
- R5: An update that hits raises the counter by one when taken, stopping at 3. It lowers the counter by one when not taken, stopping at 0.
- R6: On a fetch hit, counter values 2 and 3 give `predTaken`=1 with `predNextPc` equal to the stored target. Values 0 and 1 give `predTaken`=0 with `fetchPc`+1.
- R7: On a hit, a taken update replaces the stored target with `updTarget`. A not-taken update leaves it unchanged.
- R8: `mispredict` is combinational on the update inputs. It is 1 when `updValid` is 1 and either the resolved direction differs from the table's current direction for `updPc` (a miss counts as not taken), or the branch is taken, predicted taken, and the stored target differs from `updTarget`. In all other cases it is 0.
- R9: A lookup in the same cycle as an update to the same entry sees the contents from before the update. The update becomes visible from the next cycle.
- R10: While `updValid` is 0, the update inputs change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| fetchPc | input | PC_W | Word address being fetched |
| predNextPc | output | PC_W | Predicted next fetch address |
| predTaken | output | 1 | Prediction is a taken branch |
| updValid | input | 1 | A resolved branch is present on the update port |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Resolved direction, 1 = taken |
| updTarget | input | PC_W | Resolved target address |
| mispredict | output | 1 | Resolved branch disagrees with the current prediction |

## Verification
`predNextPc`, `predTaken` and `mispredict` are combinational, so they are due in the same cycle as the inputs that drive them. Any table change from an update is due only after the next rising edge. The bench drives inputs on the falling edge and samples the outputs 1 ns later, against a model that still holds the old table. It applies the update to its model at the rising edge, which keeps the checks aligned with that one-cycle visibility. Sweeps over every fetch PC of an 8-bit, 4-entry configuration, run after directed and pseudo-random update sequences, compare every entry's visible prediction.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // strobes issued by the update control to the table datapath
  typedef struct packed {
    logic       wrEn;        // write the indexed entry this edge
    logic       alloc;       // (re)write tag and set valid
    logic       loadTarget;  // replace the stored target
    logic [1:0] ctrNext;     // counter value to store
  } btbStrobes_t;

  localparam logic [1:0] CTR_MAX   = 2'd3;
  localparam logic [1:0] CTR_MIN   = 2'd0;
  localparam logic [1:0] CTR_WEAKT = 2'd2;
  localparam logic [1:0] CTR_WEAKN = 2'd1;
endpackage

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  output logic [PC_W-1:0] predNextPc,
  output logic            predTaken,
  input  logic [PC_W-1:0] updPc,
  input  logic [PC_W-1:0] updTarget,
  input  btbStrobes_t     strobes,
  output logic            updHit,
  output logic [1:0]      updCtr,
  output logic [PC_W-1:0] updStoredTarget
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W;

  logic              validQ  [ENTRIES];
  logic [TAG_W-1:0]  tagQ    [ENTRIES];
  logic [PC_W-1:0]   targetQ [ENTRIES];
  logic [1:0]        ctrQ    [ENTRIES];

  logic [IDX_W-1:0] fetchIdx, updIdx;
  logic [TAG_W-1:0] fetchTag, updTag;
  logic             fetchHit;

  assign fetchIdx = fetchPc[IDX_W-1:0];
  assign fetchTag = fetchPc[PC_W-1:IDX_W];
  assign updIdx   = updPc[IDX_W-1:0];
  assign updTag   = updPc[PC_W-1:IDX_W];

  // fetch-side read port
  assign fetchHit   = validQ[fetchIdx] && (tagQ[fetchIdx] == fetchTag);
  assign predTaken  = fetchHit && ctrQ[fetchIdx][1];
  assign predNextPc = predTaken ? targetQ[fetchIdx] : fetchPc + PC_W'(1);

  // update-side read port
  assign updHit          = validQ[updIdx] && (tagQ[updIdx] == updTag);
  assign updCtr          = ctrQ[updIdx];
  assign updStoredTarget = targetQ[updIdx];

  // storage, one generate slice per entry
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic selected;
    assign selected = strobes.wrEn && (updIdx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[e]  <= 1'b0;
        tagQ[e]    <= '0;
        targetQ[e] <= '0;
        ctrQ[e]    <= CTR_MIN;
      end else if (selected) begin
        ctrQ[e] <= strobes.ctrNext;
        if (strobes.alloc) begin
          validQ[e] <= 1'b1;
          tagQ[e]   <= updTag;
        end
        if (strobes.loadTarget) targetQ[e] <= updTarget;
      end
    end
  end
endmodule

// File: rtl/btb_control.sv
module btb_control
  import btb_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            updValid,
  input  logic            updTaken,
  input  logic [PC_W-1:0] updTarget,
  input  logic            updHit,
  input  logic [1:0]      updCtr,
  input  logic [PC_W-1:0] updStoredTarget,
  output btbStrobes_t     strobes,
  output logic            mispredict
);
  logic predDirTaken;
  logic [1:0] ctrStep;

  assign predDirTaken = updHit && updCtr[1];

  always_comb begin
    if (updTaken) ctrStep = (updCtr == CTR_MAX) ? CTR_MAX : updCtr + 2'd1;
    else          ctrStep = (updCtr == CTR_MIN) ? CTR_MIN : updCtr - 2'd1;
  end

  always_comb begin
    strobes.wrEn       = updValid;
    strobes.alloc      = !updHit;
    strobes.loadTarget = !updHit || updTaken;
    strobes.ctrNext    = updHit ? ctrStep : (updTaken ? CTR_WEAKT : CTR_WEAKN);
  end

  assign mispredict = updValid &&
                      ((predDirTaken != updTaken) ||
                       (updTaken && predDirTaken && (updStoredTarget != updTarget)));
endmodule

// File: rtl/btb_top.sv
module btb_top
  import btb_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  output logic [PC_W-1:0] predNextPc,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic [PC_W-1:0] updTarget,
  output logic            mispredict
);
  btbStrobes_t     strobes;
  logic            updHit;
  logic [1:0]      updCtr;
  logic [PC_W-1:0] updStoredTarget;

  btb_datapath #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .fetchPc(fetchPc), .predNextPc(predNextPc), .predTaken(predTaken),
    .updPc(updPc), .updTarget(updTarget), .strobes(strobes),
    .updHit(updHit), .updCtr(updCtr), .updStoredTarget(updStoredTarget)
  );

  btb_control #(.PC_W(PC_W)) u_ctl (
    .updValid(updValid), .updTaken(updTaken), .updTarget(updTarget),
    .updHit(updHit), .updCtr(updCtr), .updStoredTarget(updStoredTarget),
    .strobes(strobes), .mispredict(mispredict)
  );
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] fetchPc,
  input logic [PC_W-1:0] predNextPc,
  input logic            predTaken,
  input logic            updValid,
  input logic [PC_W-1:0] updPc,
  input logic            updTaken,
  input logic [PC_W-1:0] updTarget,
  input logic            mispredict
);
  logic [1:0] age;  // edges since reset released, saturating at 3
  always_ff @(posedge clk) begin
    if (!rstN) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R2 / R6: a not-taken prediction is always the sequential address
  a_r2_fallthrough: assert property (@(posedge clk) disable iff (!rstN)
    !predTaken |-> predNextPc == fetchPc + PC_W'(1));

  // R1: the first cycle after reset predicts nothing taken
  a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd0) |-> !predTaken);

  // R5 / R8: a third consecutive taken update of one branch with one target is predicted right
  a_r8_taken_trained: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2'd2 && updValid && updTaken &&
     $past(updValid) && $past(updTaken) && $past(updPc) == updPc && $past(updTarget) == updTarget &&
     $past(updValid, 2) && $past(updTaken, 2) && $past(updPc, 2) == updPc &&
     $past(updTarget, 2) == updTarget) |-> !mispredict);

  // R5 / R8: a third consecutive not-taken update of one branch is predicted right
  a_r5_nottaken_trained: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2'd2 && updValid && !updTaken &&
     $past(updValid) && !$past(updTaken) && $past(updPc) == updPc &&
     $past(updValid, 2) && !$past(updTaken, 2) && $past(updPc, 2) == updPc) |-> !mispredict);

  // R8: no flag without an update
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |-> !mispredict);
endmodule

bind btb_top btb_checker #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .predNextPc(predNextPc),
  .predTaken(predTaken), .updValid(updValid), .updPc(updPc),
  .updTaken(updTaken), .updTarget(updTarget), .mispredict(mispredict)
);

// File: tb/btb_top_test.sv
`timescale 1ns/1ps
module btb_top_test;
  localparam int PW = 8;
  localparam int IW = 2;
  localparam int NE = 1 << IW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [PW-1:0] fetchPc = '0, updPc = '0, updTarget = '0;
  logic          updValid = 1'b0, updTaken = 1'b0;
  logic [PW-1:0] predNextPc;
  logic          predTaken, mispredict;

  int compared = 0;
  int mismatched = 0;

  // reference model built from the requirements
  logic          mValid [NE];
  logic [PW-IW-1:0] mTag [NE];
  logic [PW-1:0] mTgt [NE];
  int            mCtr [NE];

  always #2.5 clk = ~clk;

  btb_top #(.PC_W(PW), .IDX_W(IW)) uut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .predNextPc(predNextPc),
    .predTaken(predTaken), .updValid(updValid), .updPc(updPc),
    .updTaken(updTaken), .updTarget(updTarget), .mispredict(mispredict)
  );

  function automatic logic mHit(input logic [PW-1:0] pc);
    return mValid[pc[IW-1:0]] && mTag[pc[IW-1:0]] == pc[PW-1:IW];
  endfunction

  function automatic logic mTaken(input logic [PW-1:0] pc);
    return mHit(pc) && mCtr[pc[IW-1:0]] >= 2;
  endfunction

  task automatic check(input string req, input logic [PW:0] act, input logic [PW:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkPred(input string req);
    logic t;
    logic [PW-1:0] n;
    t = mTaken(fetchPc);
    n = t ? mTgt[fetchPc[IW-1:0]] : fetchPc + PW'(1);
    check(req, {predTaken, predNextPc}, {t, n});
  endtask

  task automatic modelUpdate();
    int i;
    i = updPc[IW-1:0];
    if (!updValid) return;
    if (mHit(updPc)) begin
      if (updTaken) begin
        mCtr[i] = (mCtr[i] == 3) ? 3 : mCtr[i] + 1;
        mTgt[i] = updTarget;
      end else begin
        mCtr[i] = (mCtr[i] == 0) ? 0 : mCtr[i] - 1;
      end
    end else begin
      mValid[i] = 1'b1;
      mTag[i] = updPc[PW-1:IW];
      mTgt[i] = updTarget;
      mCtr[i] = updTaken ? 2 : 1;
    end
  endtask

  // one cycle: drive at falling edge, sample 1 ns later, commit model at rising edge
  task automatic step(input logic [PW-1:0] fpc, input logic uv, input logic [PW-1:0] upc,
                      input logic ut, input logic [PW-1:0] utg, input string req);
    logic expMis;
    string r;
    @(negedge clk);
    fetchPc = fpc; updValid = uv; updPc = upc; updTaken = ut; updTarget = utg;
    #1;
    r = req;
    if (r == "") r = mHit(fpc) ? "R6" : "R2";
    checkPred(r);
    expMis = uv && ((mTaken(upc) != ut) || (ut && mTaken(upc) && mTgt[upc[IW-1:0]] != utg));
    check("R8", {{PW{1'b0}}, mispredict}, {{PW{1'b0}}, expMis});
    @(posedge clk);
    modelUpdate();
  endtask

  task automatic sweep(input string req);
    for (int p = 0; p < (1 << PW); p++) step(PW'(p), 1'b0, '0, 1'b0, '0, req);
  endtask

  initial begin : watchdog
    #900000;
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    logic [15:0] lfsr;
    for (int i = 0; i < NE; i++) begin
      mValid[i] = 1'b0; mTag[i] = '0; mTgt[i] = '0; mCtr[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    sweep("R1");

    // R4: allocation on taken and on not-taken
    step(8'h00, 1'b1, 8'h41, 1'b1, 8'h90, "R2");
    step(8'h41, 1'b0, 8'h00, 1'b0, 8'h00, "R4");
    step(8'h00, 1'b1, 8'h42, 1'b0, 8'h33, "R2");
    step(8'h42, 1'b0, 8'h00, 1'b0, 8'h00, "R4");
    step(8'h42, 1'b1, 8'h42, 1'b1, 8'h33, "R4");
    step(8'h42, 1'b0, 8'h00, 1'b0, 8'h00, "R4");

    // R3: same index, different tag
    step(8'h81, 1'b0, 8'h00, 1'b0, 8'h00, "R3");
    step(8'h00, 1'b1, 8'hC1, 1'b1, 8'h17, "R3");
    step(8'h41, 1'b0, 8'h00, 1'b0, 8'h00, "R3");
    step(8'hC1, 1'b0, 8'h00, 1'b0, 8'h00, "R3");

    // R5: saturation both ways
    for (int k = 0; k < 5; k++) step(8'h20, 1'b1, 8'h20, 1'b1, 8'h5A, "R5");
    step(8'h20, 1'b1, 8'h20, 1'b0, 8'h5A, "R5");
    step(8'h20, 1'b0, 8'h00, 1'b0, 8'h00, "R5");
    for (int k = 0; k < 5; k++) step(8'h20, 1'b1, 8'h20, 1'b0, 8'h5A, "R5");
    step(8'h20, 1'b1, 8'h20, 1'b1, 8'h5A, "R5");
    step(8'h20, 1'b0, 8'h00, 1'b0, 8'h00, "R5");

    // R7: target only replaced by taken outcomes
    step(8'h00, 1'b1, 8'h13, 1'b1, 8'h20, "R2");
    step(8'h00, 1'b1, 8'h13, 1'b1, 8'h20, "R2");
    step(8'h00, 1'b1, 8'h13, 1'b0, 8'h77, "R2");
    step(8'h13, 1'b0, 8'h00, 1'b0, 8'h00, "R7");
    step(8'h00, 1'b1, 8'h13, 1'b1, 8'h55, "R2");
    step(8'h13, 1'b0, 8'h00, 1'b0, 8'h00, "R7");

    // R9: update and lookup of the same entry in one cycle
    step(8'hE3, 1'b1, 8'hE3, 1'b1, 8'h66, "R9");
    step(8'hE3, 1'b0, 8'h00, 1'b0, 8'h00, "R9");
    step(8'h13, 1'b1, 8'h13, 1'b0, 8'h01, "R9");

    // R10: changing update inputs while updValid is low
    for (int k = 0; k < 8; k++) step(8'h00, 1'b0, PW'(k * 37), k[0], PW'(k * 11), "R2");
    sweep("R10");

    // pseudo-random mixed traffic with periodic full sweeps
    lfsr = 16'hACE1;
    for (int s = 0; s < 600; s++) begin
      logic [PW-1:0] upc;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      upc = {lfsr[5:4], 4'b0000, lfsr[1:0]};
      step(lfsr[2] ? upc : lfsr[15:8], lfsr[3] | lfsr[9], upc, lfsr[6] | lfsr[7],
           {lfsr[11:10], 6'h0, 2'b00} | PW'(lfsr[12]), "");
      if (s % 150 == 149) sweep("");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule